// File: doc/BRIEF.md
# SPI EEPROM Boot Loader Master

After reset this block copies a program image from a serial EEPROM into system memory. A host pulses `start_i`. The block then pulses chip-select high and then low, and sends the read opcode 0x03. After the opcode it sends a start address of all zeros. That address is one, two or three bytes long, as set by a parameter that matches the EEPROM size.

The block then keeps chip-select low and clocks in the whole image, `PAGES` pages of 256 bytes, under that one read command. Each byte goes out through a one-cycle memory write strobe to an incrementing address that starts at `DEST_BASE`. An LED port shows how many pages are still left to load.

When the last page is stored, chip-select is released. The block then writes the jump target `START_ADDR` into low memory, high byte at 0x0001 and low byte at 0x0002, and pulses `done_o`. The SPI link runs in mode 0. SCK idles low, and each half-period of SCK lasts `CLK_DIV` system clocks. Bytes move MSB first.

Top module: `spi_boot_loader`

## Requirements
- R1: Out of reset and while idle, spi_cs_no is 1, spi_sck_o is 0, mem_we_o is 0, done_o is 0 and led_o is 0. Without a start pulse nothing changes.
- R2: On start_i, spi_cs_no is high for at least one cycle and then goes low. Before the first SCK rising edge, the first byte shifted out MSB first is 0x03.
- R3: Right after the opcode, ADDR_BYTES bytes of value 0x00 are shifted out.
- R4: SPI mode 0. SCK idles low, and each high phase lasts exactly CLK_DIV clocks. MOSI does not change while SCK is high. MISO is sampled when SCK rises.
- R5: The k-th byte received after the address (k from 0) is written with a one-cycle mem_we_o pulse to address DEST_BASE+k, with mem_data_o equal to that byte.
- R6: One read command covers the whole image. spi_cs_no falls exactly once per load, exactly PAGES*256 data writes happen, and SCK pulses only while spi_cs_no is low.
- R7: led_o loads PAGES on start. It drops by one in the same cycle as the write strobe of the last byte of each page, and at no other time.
- R8: After the last data byte, spi_cs_no is 1. Then, in two consecutive cycles, START_ADDR[15:8] is written to 0x0001 and START_ADDR[7:0] to 0x0002.
- R9: done_o is high for exactly one cycle, the cycle right after the 0x0002 write strobe.
- R10: start_i has no effect while a load is in progress, and a new start after done_o runs a complete new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a load (one-cycle pulse) |
| done_o | output | 1 | One-cycle pulse when the load and vector writes are complete |
| spi_sck_o | output | 1 | SPI clock, idles low |
| spi_cs_no | output | 1 | EEPROM chip-select, active low |
| spi_mosi_o | output | 1 | Serial data to EEPROM |
| spi_miso_i | input | 1 | Serial data from EEPROM |
| mem_addr_o | output | MEM_AW | Memory write address |
| mem_data_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe, one cycle per byte |
| led_o | output | LED_W | Remaining page count |

## Verification
Each data write strobe appears one cycle after the shifter finishes its eighth bit. The LED decrement comes in that same cycle for the last byte of a page. The 0x0001 and 0x0002 writes come in the two cycles after the final data write, and done_o follows one cycle after the 0x0002 write. The bench samples every output on the falling clock edge and stamps each event with a cycle number. Its checks compare those stamps exactly: LED value at the page-end strobe, low-vector write one cycle after the high-vector write, done one cycle after the low-vector write. It does not wait an arbitrary delay. The SPI slave model in the bench counts SCK rising edges to decode the command bytes and to present image bytes, so the framing and bit order are checked at the pins.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_ADDR,
    ST_READ,
    ST_VEC_HI,
    ST_VEC_LO,
    ST_FIN
  } boot_state_e;

  localparam logic [7:0] OPC_READ = 8'h03;

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             busy_q;
  logic             sck_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       tx_q;
  logic [7:0]       rx_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      bit_q  <= '0;
      div_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          tx_q   <= tx_i;
          bit_q  <= '0;
          div_q  <= '0;
          sck_q  <= 1'b0;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso_i};   // sample on rising edge
        end else begin
          sck_q <= 1'b0;
          tx_q  <= {tx_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);  // R4
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(mosi_o));  // R4

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import spi_boot_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int PAGES      = 128,
  parameter int PAGE_BYTES = 256,
  parameter int MEM_AW     = 16,
  parameter int DEST_BASE  = 'h8000,
  parameter int START_ADDR = 'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  output logic              sh_start_o,
  output logic [7:0]        sh_tx_o,
  output logic              cs_no,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              mem_we_o,
  output logic              done_o,
  output logic [$clog2(PAGES+1)-1:0] pages_left_o
);

  localparam int PG_W = $clog2(PAGES + 1);
  localparam int PB_W = $clog2(PAGE_BYTES);
  localparam logic [MEM_AW-1:0] VEC_HI_ADDR = MEM_AW'(1);
  localparam logic [MEM_AW-1:0] VEC_LO_ADDR = MEM_AW'(2);
  localparam logic [15:0]       START_W     = 16'(START_ADDR);

  boot_state_e       st_q;
  logic              cs_n_q;
  logic              sh_start_q;
  logic [7:0]        sh_tx_q;
  logic [1:0]        addr_cnt_q;
  logic [MEM_AW-1:0] ptr_q;
  logic [PB_W-1:0]   byte_q;
  logic [PG_W-1:0]   pages_q;
  logic              we_q;
  logic [MEM_AW-1:0] waddr_q;
  logic [7:0]        wdata_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cs_n_q     <= 1'b1;
      sh_start_q <= 1'b0;
      sh_tx_q    <= '0;
      addr_cnt_q <= '0;
      ptr_q      <= MEM_AW'(DEST_BASE);
      byte_q     <= '0;
      pages_q    <= '0;
      we_q       <= 1'b0;
      waddr_q    <= '0;
      wdata_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      sh_start_q <= 1'b0;
      we_q       <= 1'b0;
      done_q     <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_SETUP;
          cs_n_q  <= 1'b1;
          pages_q <= PG_W'(PAGES);
          ptr_q   <= MEM_AW'(DEST_BASE);
          byte_q  <= '0;
        end
        ST_SETUP: begin
          cs_n_q     <= 1'b0;
          sh_start_q <= 1'b1;
          sh_tx_q    <= OPC_READ;
          st_q       <= ST_CMD;
        end
        ST_CMD: if (sh_done_i) begin
          sh_start_q <= 1'b1;
          sh_tx_q    <= 8'h00;
          addr_cnt_q <= 2'd1;
          st_q       <= ST_ADDR;
        end
        ST_ADDR: if (sh_done_i) begin
          sh_start_q <= 1'b1;
          sh_tx_q    <= 8'h00;
          if (addr_cnt_q == 2'(ADDR_BYTES)) st_q <= ST_READ;
          else addr_cnt_q <= addr_cnt_q + 2'd1;
        end
        ST_READ: if (sh_done_i) begin
          we_q    <= 1'b1;
          waddr_q <= ptr_q;
          wdata_q <= sh_rx_i;
          ptr_q   <= ptr_q + MEM_AW'(1);
          byte_q  <= byte_q + PB_W'(1);
          if (byte_q == PB_W'(PAGE_BYTES - 1)) begin
            byte_q  <= '0;
            pages_q <= pages_q - PG_W'(1);
            if (pages_q == PG_W'(1)) begin
              cs_n_q <= 1'b1;
              st_q   <= ST_VEC_HI;
            end else begin
              sh_start_q <= 1'b1;
            end
          end else begin
            sh_start_q <= 1'b1;
          end
        end
        ST_VEC_HI: begin
          we_q    <= 1'b1;
          waddr_q <= VEC_HI_ADDR;
          wdata_q <= START_W[15:8];
          st_q    <= ST_VEC_LO;
        end
        ST_VEC_LO: begin
          we_q    <= 1'b1;
          waddr_q <= VEC_LO_ADDR;
          wdata_q <= START_W[7:0];
          st_q    <= ST_FIN;
        end
        ST_FIN: begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sh_start_o   = sh_start_q;
  assign sh_tx_o      = sh_tx_q;
  assign cs_no        = cs_n_q;
  assign mem_addr_o   = waddr_q;
  assign mem_data_o   = wdata_q;
  assign mem_we_o     = we_q;
  assign done_o       = done_q;
  assign pages_left_o = pages_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);  // R9
  AST_VEC_AFTER_CS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && (waddr_q == VEC_HI_ADDR || waddr_q == VEC_LO_ADDR)) |-> cs_n_q);  // R8
  AST_PAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) != ST_IDLE && pages_q != $past(pages_q)) |-> (pages_q == $past(pages_q) - PG_W'(1)));  // R7
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q == ST_READ) |=> (st_q != ST_SETUP));  // R10

endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader #(
  parameter int ADDR_BYTES = 3,
  parameter int PAGES      = 128,
  parameter int CLK_DIV    = 2,
  parameter int MEM_AW     = 16,
  parameter int LED_W      = 8,
  parameter int DEST_BASE  = 'h8000,
  parameter int START_ADDR = 'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic              spi_sck_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              mem_we_o,
  output logic [LED_W-1:0]  led_o
);

  localparam int PAGE_BYTES = 256;
  localparam int PG_W       = $clog2(PAGES + 1);

  logic            sh_start;
  logic [7:0]      sh_tx;
  logic [7:0]      sh_rx;
  logic            sh_done;
  logic [PG_W-1:0] pages_left;

  spi_byte_shifter #(.CLK_DIV(CLK_DIV)) i_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sh_start),
    .tx_i   (sh_tx),
    .miso_i (spi_miso_i),
    .sck_o  (spi_sck_o),
    .mosi_o (spi_mosi_o),
    .rx_o   (sh_rx),
    .done_o (sh_done)
  );

  boot_seq_fsm #(
    .ADDR_BYTES(ADDR_BYTES),
    .PAGES     (PAGES),
    .PAGE_BYTES(PAGE_BYTES),
    .MEM_AW    (MEM_AW),
    .DEST_BASE (DEST_BASE),
    .START_ADDR(START_ADDR)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sh_done_i   (sh_done),
    .sh_rx_i     (sh_rx),
    .sh_start_o  (sh_start),
    .sh_tx_o     (sh_tx),
    .cs_no       (spi_cs_no),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .mem_we_o    (mem_we_o),
    .done_o      (done_o),
    .pages_left_o(pages_left)
  );

  assign led_o = LED_W'(pages_left);

  AST_SCK_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> !spi_cs_no);  // R6
  AST_DATA_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !spi_cs_no) |=> !mem_we_o);  // R5

endmodule

// File: tb/test_spi_boot_loader.sv
`timescale 1ns/1ps
module test_spi_boot_loader;

  localparam int AB     = 2;
  localparam int NPG    = 3;
  localparam int DIV    = 2;
  localparam int DEST   = 'h8000;
  localparam int JMP    = 'h8123;
  localparam int CMD_BITS = 8 * (1 + AB);
  localparam int NBYTES = NPG * 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, sck, cs_n, mosi, miso, we;
  logic [15:0] addr;
  logic [7:0] data, led;

  always #2 clk = ~clk;

  spi_boot_loader #(
    .ADDR_BYTES(AB), .PAGES(NPG), .CLK_DIV(DIV), .MEM_AW(16), .LED_W(8),
    .DEST_BASE(DEST), .START_ADDR(JMP)
  ) i_spi_boot_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .mem_addr_o(addr), .mem_data_o(data), .mem_we_o(we), .led_o(led)
  );

  int checks = 0;
  int errors = 0;
  int seed = 0;

  function automatic logic [7:0] pat(int k, int s);
    return 8'(k * 37 + s) ^ 8'(k >> 8);
  endfunction

  // SPI slave model
  int bitpos = 0;
  int cs_falls = 0;
  logic [31:0] cmd_bits = '0;
  always @(negedge cs_n or posedge sck) begin
    if (!sck) begin
      bitpos = 0;
      cmd_bits = '0;
      cs_falls++;
    end else if (!cs_n) begin
      if (bitpos < CMD_BITS) cmd_bits = {cmd_bits[30:0], mosi};
      bitpos++;
    end
  end

  always_comb begin
    if (bitpos < CMD_BITS) miso = 1'b0;
    else begin
      automatic int n = bitpos - CMD_BITS;
      automatic logic [7:0] b = pat(n / 8, seed);
      miso = b[7 - (n % 8)];
    end
  end

  // monitors on falling edge
  int cyc = 0;
  int wr_cnt = 0, data_err = 0, led_err = 0;
  int bad_k = -1, bad_act = 0, bad_exp = 0;
  int vh_cyc = -1, vl_cyc = -1, done_cyc = -1, done_cnt = 0;
  int vh_data = 0, vl_data = 0, vh_cs = 0;
  int hi_len = 0, sck_err = 0, mosi_err = 0, first_rise = -1, cs_fall_cyc = -1;
  logic prev_sck = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) cs_fall_cyc = cyc;
    if (sck && !prev_sck && first_rise < 0) first_rise = cyc;
    if (we) begin
      if (addr == 16'h0001) begin
        vh_cyc = cyc; vh_data = int'(data); vh_cs = int'(cs_n);
      end else if (addr == 16'h0002) begin
        vl_cyc = cyc; vl_data = int'(data);
      end else begin
        if (addr != 16'(DEST + wr_cnt) || data != pat(wr_cnt, seed)) begin
          if (bad_k < 0) begin
            bad_k = wr_cnt; bad_act = int'({addr, data});
            bad_exp = int'({16'(DEST + wr_cnt), pat(wr_cnt, seed)});
          end
          data_err++;
        end
        if (int'(led) != NPG - (wr_cnt + 1) / 256) led_err++;
        wr_cnt++;
      end
    end
    if (done) begin done_cyc = cyc; done_cnt++; end
    if (sck) begin
      hi_len++;
      if (prev_sck && mosi != prev_mosi) mosi_err++;
    end else if (prev_sck) begin
      if (hi_len != DIV) sck_err++;
      hi_len = 0;
    end
    if (sck && cs_n) sck_err++;
    prev_sck = sck; prev_mosi = mosi; prev_cs = cs_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    wr_cnt = 0; data_err = 0; led_err = 0; bad_k = -1;
    vh_cyc = -1; vl_cyc = -1; done_cyc = -1; done_cnt = 0;
    sck_err = 0; mosi_err = 0; first_rise = -1; cs_fall_cyc = -1;
    cs_falls = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 cs/sck idle", int'({cs_n, sck}), 2);
    chk(we == 1'b0 && done == 1'b0, "R1 we/done idle", int'({we, done}), 0);
    chk(led == 8'h00, "R1 led reset", int'(led), 0);
  endtask

  task automatic t_idle_no_start();
    clear_mon();
    repeat (200) @(negedge clk);
    chk(cs_falls == 0 && wr_cnt == 0, "R1 no activity without start", cs_falls + wr_cnt, 0);
    chk(done_cnt == 0 && cs_n == 1'b1, "R1 stays idle", done_cnt, 0);
  endtask

  task automatic t_load(input int s, input bit extra_start);
    int t0;
    clear_mon();
    seed = s;
    pulse_start();
    t0 = cyc;
    repeat (3) @(negedge clk);
    chk(int'(led) == NPG, "R7 led loads page count", int'(led), NPG);
    if (extra_start) begin
      repeat (2000) @(negedge clk);
      pulse_start();
    end
    for (int i = 0; i < 60000 && done_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(cs_fall_cyc > t0 && first_rise > cs_fall_cyc, "R2 cs high then low before sck",
        first_rise - cs_fall_cyc, 1);
    chk(cmd_bits == (32'h3 << (8 * AB)), "R2 R3 opcode and zero address",
        int'(cmd_bits), int'(32'h3 << (8 * AB)));
    chk(sck_err == 0 && mosi_err == 0, "R4 sck phase and mosi hold", sck_err + mosi_err, 0);
    chk(data_err == 0, "R5 data writes", bad_act, bad_exp);
    chk(wr_cnt == NBYTES, "R6 byte count", wr_cnt, NBYTES);
    chk(cs_falls == 1, extra_start ? "R10 single read command" : "R6 single read command",
        cs_falls, 1);
    chk(led_err == 0 && led == 8'h00, "R7 led per page", led_err, 0);
    chk(vh_cs == 1 && vh_data == (JMP >> 8), "R8 high vector after cs off",
        (vh_cs << 8) | vh_data, (1 << 8) | (JMP >> 8));
    chk(vl_cyc == vh_cyc + 1 && vl_data == (JMP & 'hff), "R8 low vector next cycle",
        vl_data, JMP & 'hff);
    chk(done_cnt == 1 && done_cyc == vl_cyc + 1, "R9 done one pulse after vector",
        done_cyc - vl_cyc, 1);
    chk(cs_n == 1'b1 && sck == 1'b0 && done == 1'b0, "R1 idle after load",
        int'({cs_n, sck, done}), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_no_start();
    t_load(5, 1'b0);
    t_load(91, 1'b1);
    t_load(200, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule